// File: doc/BRIEF.md
# Score Memory Operation Controller

This block owns a small command register file that sits over the first bytes of a 64-byte work RAM, together with an engine that copies whole tables between that RAM and a 256-byte score memory. The score memory is held inside the block as four 64-byte tables. Software writes an operation byte and then pulses a trigger strobe. The engine decodes the byte. If the operation is legal, the engine holds `busy` high through a programmable access delay and then carries the operation out. The engine can fill the RAM from a table, store the RAM into a table, clear the whole score memory, or tell a separate music fetcher which of seven tunes to start.

The same register port also gives access to an 8-bit pseudo-random generator, which software can seed and read. Software can also read back the error code left by the last triggered operation. The RAM is external to the block and has an asynchronous read port. The block drives the address for both reads and writes.

Top module: `score_op_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `tune_load` is 0, `ram_we` is 0, register 0 reads 0x00, the generator state is 0x01, and all 256 score bytes are 0x00.
- R2: A write to register 0 stores the operation byte. On a trigger, bits [3:0] of that byte are the opcode and bits [7:4] are the index. The opcodes are 1 = start tune, 2 = load table, 3 = save table and 4 = wipe.
- R3: A write to register 1 loads the generator state with the written byte. A written value of 0x00 loads 0x01 instead, so the state is never zero.
- R4: While `reg_addr` is 1, `rdata` shows the next generator value {s[6:0], s[7]^s[5]^s[4]^s[3]}, which is the polynomial x^8+x^6+x^5+x^4+1. A read strobe at address 1 moves the state to that value.
- R5: Register 0 reads 0x01 after a trigger is rejected and 0x00 after a trigger is accepted. A trigger is rejected when the opcode is not 1 to 4, when a tune index is above 6, or when a table index is above 3. A rejected trigger leaves `busy` low and changes neither memory.
- R6: When a trigger is accepted, `busy` is high from the next cycle for WAIT_CYCLES delay cycles plus an execution phase. The execution phase lasts 64 cycles for a load or a save and 1 cycle for a tune start or a wipe. Triggers that arrive while `busy` is high are ignored.
- R7: A load of table N writes score bytes 64N+k to RAM address k. It writes one byte per cycle, for k from 0 to 63 in order.
- R8: A save of table N stores RAM address k into score byte 64N+k for every k from 0 to 63, and leaves the other tables unchanged.
- R9: A wipe sets all 256 score bytes to 0x00, whatever the index.
- R10: A tune start produces a single-cycle `tune_load` pulse after the delay, with `tune_sel` equal to the index.
- R11: An operation already in progress uses the operation byte that was latched at its trigger. Later writes to register 0 do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 operation/error, 1 random seed/value |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| hotspot | input | 1 | Trigger strobe that starts the latched operation |
| busy | output | 1 | High while an operation waits or executes |
| tune_load | output | 1 | One-cycle pulse that starts a tune |
| tune_sel | output | 3 | Selected tune, valid with `tune_load` |
| ram_we | output | 1 | Work RAM write enable |
| ram_addr | output | 6 | Work RAM address |
| ram_wdata | output | 8 | Work RAM write data |
| ram_rdata | input | 8 | Work RAM asynchronous read data |

## Verification
The assertions assume that `ram_rdata` follows `ram_addr` within the same cycle. They also assume that the strobes are clean single-cycle levels that are never X after reset. The bench meets both conditions: it models the RAM as an array with a combinational read and drives every input from tasks on the falling edge. The random part of the stimulus picks tables, seeds and RAM contents freely. Triggers that arrive while the block is busy are produced on purpose, so that the assertions on ignoring them and on the latched index are exercised.

// File: rtl/score_ctrl_pkg.sv
package score_ctrl_pkg;
  localparam int TBL_CNT   = 4;
  localparam int TBL_BYTES = 64;
  localparam int MEM_BYTES = TBL_CNT * TBL_BYTES;
  localparam int TBL_AW    = $clog2(TBL_BYTES);
  localparam int MEM_AW    = $clog2(MEM_BYTES);

  localparam logic [3:0] OPC_TUNE = 4'd1;
  localparam logic [3:0] OPC_LOAD = 4'd2;
  localparam logic [3:0] OPC_SAVE = 4'd3;
  localparam logic [3:0] OPC_WIPE = 4'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_LOAD, ST_SAVE, ST_WIPE, ST_TUNE
  } state_t;

  typedef struct packed {
    logic       ok;
    state_t     exec;
    logic [3:0] idx;
  } op_dec_t;

  // Fibonacci step, taps x^8+x^6+x^5+x^4+1
  function automatic logic [7:0] lfsr_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic op_dec_t op_decode(input logic [7:0] op, input int tune_count);
    op_dec_t d;
    d.idx  = op[7:4];
    d.exec = ST_IDLE;
    d.ok   = 1'b0;
    case (op[3:0])
      OPC_TUNE: begin d.exec = ST_TUNE; d.ok = (int'(op[7:4]) < tune_count); end
      OPC_LOAD: begin d.exec = ST_LOAD; d.ok = (int'(op[7:4]) < TBL_CNT); end
      OPC_SAVE: begin d.exec = ST_SAVE; d.ok = (int'(op[7:4]) < TBL_CNT); end
      OPC_WIPE: begin d.exec = ST_WIPE; d.ok = 1'b1; end
      default:  begin d.exec = ST_IDLE; d.ok = 1'b0; end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/score_rng.sv
module score_rng
  import score_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seed_we,
  input  logic [7:0] seed,
  input  logic       adv,
  output logic [7:0] next_val
);
  logic [7:0] state_q;

  assign next_val = lfsr_step(state_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= 8'h01;
    else if (seed_we) state_q <= (seed == 8'h00) ? 8'h01 : seed;
    else if (adv)     state_q <= next_val;
  end

  // R3
  rng_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) state_q != 8'h00);
  // R4
  rng_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !seed_we) |=> state_q == $past(next_val));
endmodule

// File: rtl/score_op_decode.sv
module score_op_decode
  import score_ctrl_pkg::*;
#(
  parameter int TUNE_COUNT = 7
) (
  input  logic [7:0] op,
  output op_dec_t    dec
);
  always_comb dec = op_decode(op, TUNE_COUNT);
endmodule

// File: rtl/score_mem.sv
module score_mem
  import score_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              we,
  input  logic [MEM_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] mem_q [MEM_BYTES];

  assign rdata = mem_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'h00;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end
endmodule

// File: rtl/score_op_ctrl.sv
module score_op_ctrl
  import score_ctrl_pkg::*;
#(
  parameter int WAIT_CYCLES = 20,
  parameter int TUNE_COUNT  = 7,
  localparam int CW = $clog2(WAIT_CYCLES + TBL_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              hotspot,
  output logic              busy,
  output logic              tune_load,
  output logic [2:0]        tune_sel,
  output logic              ram_we,
  output logic [TBL_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);
  state_t          state_q, exec_q;
  logic [CW-1:0]   cnt_q;
  logic [3:0]      idx_q;
  logic [7:0]      op_q;
  logic            err_q;
  op_dec_t         dec;
  logic [7:0]      rng_val;
  logic [7:0]      mem_rdata;
  logic            trig, accept, reject, copy_act;

  score_op_decode #(.TUNE_COUNT(TUNE_COUNT)) u_dec (.op(op_q), .dec(dec));

  score_rng u_rng (
    .clk(clk), .rst_n(rst_n),
    .seed_we(reg_wr && reg_addr == 2'd1), .seed(wdata),
    .adv(reg_rd && reg_addr == 2'd1), .next_val(rng_val)
  );

  score_mem u_mem (
    .clk(clk), .rst_n(rst_n),
    .wipe(state_q == ST_WIPE),
    .we(state_q == ST_SAVE),
    .addr({idx_q[1:0], cnt_q[TBL_AW-1:0]}),
    .wdata(ram_rdata),
    .rdata(mem_rdata)
  );

  assign busy      = (state_q != ST_IDLE);
  assign trig      = hotspot && !busy;
  assign accept    = trig && dec.ok;
  assign reject    = trig && !dec.ok;
  assign copy_act  = (state_q == ST_LOAD) || (state_q == ST_SAVE);
  assign ram_we    = (state_q == ST_LOAD);
  assign ram_addr  = cnt_q[TBL_AW-1:0];
  assign ram_wdata = mem_rdata;
  assign tune_load = (state_q == ST_TUNE);
  assign tune_sel  = idx_q[2:0];

  always_comb begin
    case (reg_addr)
      2'd0:    rdata = {7'd0, err_q};
      2'd1:    rdata = rng_val;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      exec_q  <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      op_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) op_q <= wdata;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_WAIT;
            cnt_q   <= CW'(WAIT_CYCLES - 1);
            exec_q  <= dec.exec;
            idx_q   <= dec.idx;
            err_q   <= 1'b0;
          end else if (reject) begin
            err_q   <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) state_q <= exec_q;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_LOAD, ST_SAVE: begin
          if (cnt_q[TBL_AW-1:0] == TBL_AW'(TBL_BYTES - 1)) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (!busy && rdata_err_bit()));
  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hotspot) |=> $stable(idx_q));
  // R7
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> busy);
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_act && ram_addr != TBL_AW'(TBL_BYTES - 1)) |=>
      (copy_act && ram_addr == $past(ram_addr) + 1'b1));
  // R10
  tune_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tune_load |=> !tune_load);

  function automatic logic rdata_err_bit();
    return err_q;
  endfunction
endmodule

// File: tb/score_op_ctrl_tb.sv
module score_op_ctrl_tb;
  localparam int W = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, hotspot = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       busy, tune_load, ram_we;
  logic [2:0] tune_sel;
  logic [5:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata;

  logic [7:0] ram [64];
  logic [7:0] exp_mem [256];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  score_op_ctrl #(.WAIT_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .wdata(wdata), .rdata(rdata), .hotspot(hotspot), .busy(busy),
    .tune_load(tune_load), .tune_sel(tune_sel), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  assign ram_rdata = ram[ram_addr];
  always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

  function automatic logic [7:0] rng_model(input logic [7:0] s);
    logic fb;
    fb = ^(s & 8'b1011_1000);
    return {s[6:0], fb};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  // issue op, run until idle; report busy length, pulses, address order errors
  task automatic run_op(input logic [7:0] op, input bit poke,
                        output int blen, output int pulses, output int sel,
                        output int order_err, output int we_cnt);
    int k;
    wr(2'd0, op);
    hotspot = 1; @(negedge clk); hotspot = 0;
    blen = 0; pulses = 0; sel = -1; order_err = 0; we_cnt = 0; k = 0;
    while (busy && blen < 2000) begin
      if (ram_we) begin
        we_cnt++;
        if (ram_addr != 6'(k)) order_err++;
        k++;
      end
      if (tune_load) begin pulses++; sel = tune_sel; end
      if (poke && blen == 5) begin
        reg_wr = 1; reg_addr = 2'd0; wdata = 8'h12; hotspot = 1;
      end else begin
        reg_wr = 0; hotspot = 0;
      end
      blen++;
      @(negedge clk);
    end
    reg_wr = 0; hotspot = 0;
  endtask

  task automatic rand_ram();
    for (int i = 0; i < 64; i++) ram[i] = 8'($urandom);
  endtask

  task automatic err_is(input int e, input string req);
    reg_addr = 2'd0; #1;
    check(rdata == 8'(e), req, rdata, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int blen, pulses, sel, oerr, wec, t, t2;
    logic [7:0] s, snap [64];
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    rand_ram();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(busy == 0 && tune_load == 0 && ram_we == 0, "R1 idle outputs", busy, 0);
    err_is(0, "R1 error reg");
    reg_addr = 2'd1; #1;
    check(rdata == rng_model(8'h01), "R1 rng state", rdata, rng_model(8'h01));
    @(negedge clk);

    // R1 score memory zero: load each table
    for (int tb = 0; tb < 4; tb++) begin
      rand_ram();
      run_op({4'(tb), 4'd2}, 0, blen, pulses, sel, oerr, wec);
      t = 0;
      for (int i = 0; i < 64; i++) if (ram[i] != 8'h00) t++;
      check(t == 0, "R1 table zero after reset", t, 0);
    end

    // R3/R4 seeds and sequences
    for (int n = 0; n < 6; n++) begin
      s = (n == 0) ? 8'h00 : 8'($urandom);
      wr(2'd1, s);
      if (s == 8'h00) s = 8'h01;
      for (int j = 0; j < 20; j++) begin
        reg_addr = 2'd1; #1;
        s = rng_model(s);
        check(rdata == s, (n == 0) ? "R3 zero seed" : "R4 lfsr seq", rdata, s);
        reg_rd = 1; @(negedge clk); reg_rd = 0;
      end
    end

    // R2/R6/R7/R8 save then load, random tables
    for (int n = 0; n < 8; n++) begin
      t = $urandom_range(0, 3);
      rand_ram();
      for (int i = 0; i < 64; i++) snap[i] = ram[i];
      run_op({4'(t), 4'd3}, 0, blen, pulses, sel, oerr, wec);
      check(blen == W + 64, "R6 save busy length", blen, W + 64);
      check(wec == 0, "R8 save writes no RAM", wec, 0);
      for (int i = 0; i < 64; i++) exp_mem[t*64+i] = snap[i];
      err_is(0, "R5 error after good op");
      t2 = $urandom_range(0, 3);
      rand_ram();
      run_op({4'(t2), 4'd2}, 0, blen, pulses, sel, oerr, wec);
      check(blen == W + 64 && wec == 64, "R6 load busy length", blen, W + 64);
      check(oerr == 0, "R7 address order", oerr, 0);
      t = 0;
      for (int i = 0; i < 64; i++) if (ram[i] != exp_mem[t2*64+i]) t++;
      check(t == 0, "R7 R8 R2 loaded table contents", t, 0);
    end

    // R6/R11 trigger during busy ignored; saves to table 3, not table 1
    rand_ram();
    for (int i = 0; i < 64; i++) snap[i] = ram[i];
    run_op({4'd3, 4'd3}, 1, blen, pulses, sel, oerr, wec);
    check(blen == W + 64, "R6 busy not restarted", blen, W + 64);
    for (int i = 0; i < 64; i++) exp_mem[192+i] = snap[i];
    for (int tb = 1; tb < 4; tb += 2) begin
      rand_ram();
      run_op({4'(tb), 4'd2}, 0, blen, pulses, sel, oerr, wec);
      t = 0;
      for (int i = 0; i < 64; i++) if (ram[i] != exp_mem[tb*64+i]) t++;
      check(t == 0, "R11 latched index used", t, 0);
    end

    // R10 tune starts
    for (int n = 0; n < 7; n++) begin
      run_op({4'(n), 4'd1}, 0, blen, pulses, sel, oerr, wec);
      check(pulses == 1 && sel == n, "R10 tune pulse/select", sel, n);
      check(blen == W + 1, "R6 tune busy length", blen, W + 1);
    end

    // R5 rejects
    begin
      logic [7:0] bad [6] = '{8'h71, 8'hF1, 8'h42, 8'h53, 8'h00, 8'h25};
      for (int n = 0; n < 6; n++) begin
        run_op(bad[n], 0, blen, pulses, sel, oerr, wec);
        check(blen == 0 && wec == 0 && pulses == 0, "R5 rejected op idle", blen, 0);
        err_is(1, "R5 error code");
      end
    end
    for (int tb = 0; tb < 4; tb++) begin
      rand_ram();
      run_op({4'(tb), 4'd2}, 0, blen, pulses, sel, oerr, wec);
      t = 0;
      for (int i = 0; i < 64; i++) if (ram[i] != exp_mem[tb*64+i]) t++;
      check(t == 0, "R5 memory unchanged after rejects", t, 0);
    end

    // R9 wipe with nonzero index
    run_op({4'd9, 4'd4}, 0, blen, pulses, sel, oerr, wec);
    check(blen == W + 1, "R9 wipe busy length", blen, W + 1);
    err_is(0, "R9 wipe accepted");
    for (int tb = 0; tb < 4; tb++) begin
      rand_ram();
      run_op({4'(tb), 4'd2}, 0, blen, pulses, sel, oerr, wec);
      t = 0;
      for (int i = 0; i < 64; i++) if (ram[i] != 8'h00) t++;
      check(t == 0, "R9 table cleared", t, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule